// File: doc/BRIEF.md
# Twelve-Bit Memory Reference Executor

This block carries out one memory-reference instruction of a 12-bit, word-addressed accumulator machine. The main controller has already fetched the instruction and stepped the program counter. It pulses `start` with the instruction word, the incremented PC, the accumulator and the link. The block forms the effective address and follows one level of indirection, pre-incrementing the page-zero pointer words on the way. It then performs the operation against a synchronous single-port memory of 4096 words and pulses `done` with the new PC, AC and link on its outputs.

The memory returns read data one cycle after a read strobe. Writes take effect at the clock edge on which the write strobe is sampled. Between operations the result outputs keep their values, so the controller can pick them up whenever it suits.

Top module: `mrx_exec`

## Requirements
- R1: The instruction port is 12 bits wide, and bit 11 is its most significant bit. The opcode sits in bits [11:9], with 0=AND, 1=TAD, 2=ISZ, 3=DCA, 4=JMS and 5=JMP. Bit 8 is the indirect flag, bit 7 is the page select, and bits [6:0] are the offset. With page select 1, the effective address is pc_in[11:7] followed by the offset. With page select 0, it is five zero bits followed by the offset.
- R2: With the indirect flag set, the word read at the formed address becomes the effective address.
- R3: On an indirect reference whose formed address is 8 to 15 (octal 0010 to 0017), the pointer word is incremented modulo 4096. It is written back to that address, and the incremented value is the effective address.
- R4: AND replaces AC with AC bitwise-AND the operand. The link is unchanged.
- R5: TAD adds the operand to AC modulo 4096. A carry out of bit 11 complements the link.
- R6: ISZ writes the operand plus one, modulo 4096, back to the effective address. When that result is zero, pc_out is pc_in plus one, modulo 4096. Otherwise pc_out is pc_in.
- R7: DCA writes AC to the effective address, then sets AC to zero. The link is unchanged.
- R8: JMS writes pc_in to the effective address, and pc_out becomes the effective address plus one, modulo 4096.
- R9: JMP sets pc_out to the effective address. AND, TAD, ISZ, DCA and JMP leave AC and the link equal to their inputs unless an earlier requirement says otherwise.
- R10: `done` is high for exactly one cycle. The count of rising edges from the edge that samples `start` to the first cycle in which `done` is high is 2, plus 1 for AND, TAD or ISZ, plus 1 more for ISZ, plus 1 if indirect, plus 1 if the pointer is auto-incremented.
- R11: During and just after reset, `done`, `mem_re` and `mem_we` are low, and pc_out, ac_out and link_out are zero.
- R12: `mem_re` and `mem_we` are never high in the same cycle. Read data is taken in the cycle after the read strobe.
- R13: While the block is idle and `start` is low, pc_out, ac_out and link_out hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 12 | Memory-reference instruction word |
| pc_in | input | 12 | Program counter, already incremented past the instruction |
| ac_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link before the instruction |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 12 | Updated program counter |
| ac_out | output | 12 | Updated accumulator |
| link_out | output | 1 | Updated link |

## Verification
The assertions assume that `start` arrives only while the block is idle, that the opcode is one of 0 to 5, and that the memory answers a read strobe with data on the following cycle. The bench keeps to these assumptions. It raises `start` for a single cycle only after the previous `done`, and it sweeps only the six memory-reference opcodes. Its memory model reads and writes with exactly that one-cycle timing. The sweep covers both pages, both addressing modes and offsets on each side of the auto-increment window. It also forces operands of 4095 and pointers of 4095 so that the ISZ skip and the pointer wrap to zero both occur.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_READ_PTR   = 3'd1,
        S_WRITE_PTR  = 3'd2,
        S_EXEC       = 3'd3,
        S_READ_OPND  = 3'd4,
        S_WRITE_BACK = 3'd5,
        S_DONE       = 3'd6
    } mrx_state_e;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_TAD  = 3'd1,
        OP_ISZ  = 3'd2,
        OP_DCA  = 3'd3,
        OP_JMS  = 3'd4,
        OP_JMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } mrx_op_e;

endpackage

// File: rtl/mrx_ea.sv
`timescale 1ns/1ps
// Effective address formation and auto-increment window detection.
module mrx_ea #(
    parameter int WORD_W    = 12,
    parameter int OFF_W     = 7,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input  logic                  page_sel,
    input  logic [OFF_W-1:0]      offset,
    input  logic [WORD_W-OFF_W-1:0] pc_page,
    output logic [WORD_W-1:0]     ea,
    output logic                  auto_hit
);
    localparam int PAGE_W = WORD_W - OFF_W;

    always_comb begin
        if (page_sel) ea = {pc_page, offset};
        else          ea = {{PAGE_W{1'b0}}, offset};
    end

    generate
        if (AUTO_CNT > 0) begin : g_auto
            localparam logic [WORD_W:0] LO = (WORD_W+1)'(AUTO_BASE);
            localparam logic [WORD_W:0] HI = (WORD_W+1)'(AUTO_BASE + AUTO_CNT);
            assign auto_hit = ({1'b0, ea} >= LO) && ({1'b0, ea} < HI);
        end else begin : g_no_auto
            assign auto_hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mrx_alu.sv
`timescale 1ns/1ps
// Arithmetic for AND / TAD and the shared increment path.
module mrx_alu
    import mrx_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  mrx_op_e           op,
    input  logic [WORD_W-1:0] ac,
    input  logic              link,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] ac_r,
    output logic              link_r,
    output logic [WORD_W-1:0] inc_val,
    output logic              inc_zero
);
    logic [WORD_W:0] sum;

    assign sum      = {1'b0, ac} + {1'b0, opnd};
    assign inc_val  = opnd + WORD_W'(1);
    assign inc_zero = (inc_val == '0);

    always_comb begin
        ac_r   = ac;
        link_r = link;
        case (op)
            OP_AND: ac_r = ac & opnd;
            OP_TAD: begin
                ac_r   = sum[WORD_W-1:0];
                link_r = link ^ sum[WORD_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mrx_exec.sv
`timescale 1ns/1ps
// Memory reference executor: top-level sequencer.
module mrx_exec
    import mrx_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int OFF_W     = 7,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] ac_in,
    input  logic              link_in,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] ac_out,
    output logic              link_out
);
    localparam int OPC_HI   = WORD_W - 1;
    localparam int OPC_LO   = WORD_W - 3;
    localparam int IND_BIT  = WORD_W - 4;
    localparam int PAGE_BIT = WORD_W - 5;

    typedef struct packed {
        mrx_state_e        state;
        mrx_op_e           op;
        logic [WORD_W-1:0] ea;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] wb;
        logic              link;
        logic              auto;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0] ea_new;
    logic              auto_new;
    logic [WORD_W-1:0] alu_ac, alu_inc;
    logic              alu_link, alu_inc_zero;

    mrx_ea #(
        .WORD_W   (WORD_W),
        .OFF_W    (OFF_W),
        .AUTO_BASE(AUTO_BASE),
        .AUTO_CNT (AUTO_CNT)
    ) u_ea (
        .page_sel(instr[PAGE_BIT]),
        .offset  (instr[OFF_W-1:0]),
        .pc_page (pc_in[WORD_W-1:OFF_W]),
        .ea      (ea_new),
        .auto_hit(auto_new)
    );

    mrx_alu #(.WORD_W(WORD_W)) u_alu (
        .op      (r_q.op),
        .ac      (r_q.ac),
        .link    (r_q.link),
        .opnd    (mem_rdata),
        .ac_r    (alu_ac),
        .link_r  (alu_link),
        .inc_val (alu_inc),
        .inc_zero(alu_inc_zero)
    );

    always_comb begin
        r_d       = r_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ea;
        mem_wdata = r_q.wb;
        case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.op   = mrx_op_e'(instr[OPC_HI:OPC_LO]);
                    r_d.pc   = pc_in;
                    r_d.ac   = ac_in;
                    r_d.link = link_in;
                    r_d.ea   = ea_new;
                    r_d.auto = auto_new;
                    if (instr[IND_BIT]) begin
                        mem_re    = 1'b1;
                        mem_addr  = ea_new;
                        r_d.state = S_READ_PTR;
                    end else begin
                        r_d.state = S_EXEC;
                    end
                end
            end
            S_READ_PTR: begin
                if (r_q.auto) begin
                    r_d.wb    = alu_inc;
                    r_d.state = S_WRITE_PTR;
                end else begin
                    r_d.ea    = mem_rdata;
                    r_d.state = S_EXEC;
                end
            end
            S_WRITE_PTR: begin
                mem_we    = 1'b1;
                r_d.ea    = r_q.wb;
                r_d.state = S_EXEC;
            end
            S_EXEC: begin
                case (r_q.op)
                    OP_AND, OP_TAD, OP_ISZ: begin
                        mem_re    = 1'b1;
                        r_d.state = S_READ_OPND;
                    end
                    OP_DCA: begin
                        mem_we    = 1'b1;
                        mem_wdata = r_q.ac;
                        r_d.ac    = '0;
                        r_d.state = S_DONE;
                    end
                    OP_JMS: begin
                        mem_we    = 1'b1;
                        mem_wdata = r_q.pc;
                        r_d.pc    = r_q.ea + WORD_W'(1);
                        r_d.state = S_DONE;
                    end
                    OP_JMP: begin
                        r_d.pc    = r_q.ea;
                        r_d.state = S_DONE;
                    end
                    default: r_d.state = S_DONE;
                endcase
            end
            S_READ_OPND: begin
                r_d.ac   = alu_ac;
                r_d.link = alu_link;
                if (r_q.op == OP_ISZ) begin
                    r_d.wb = alu_inc;
                    if (alu_inc_zero) r_d.pc = r_q.pc + WORD_W'(1);
                    r_d.state = S_WRITE_BACK;
                end else begin
                    r_d.state = S_DONE;
                end
            end
            S_WRITE_BACK: begin
                mem_we    = 1'b1;
                r_d.state = S_DONE;
            end
            S_DONE:  r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done     = (r_q.state == S_DONE);
    assign pc_out   = r_q.pc;
    assign ac_out   = r_q.ac;
    assign link_out = r_q.link;
endmodule

// File: rtl/mrx_checker.sv
`timescale 1ns/1ps
module mrx_checker
    import mrx_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int AUTO_BASE = 8,
    parameter int AUTO_CNT  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] pc_out,
    input logic [WORD_W-1:0] ac_out,
    input logic              link_out,
    input logic [WORD_W-1:0] ea,
    input mrx_state_e        state,
    input mrx_op_e           op
);
    p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_dca_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_DCA) |-> (ac_out == '0));

    p_jmp_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_JMP) |-> (pc_out == ea));

    p_isz_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE_BACK) |-> (mem_we && mem_addr == ea));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=>
            ($stable(pc_out) && $stable(ac_out) && $stable(link_out)));

    generate
        if (AUTO_CNT > 0) begin : g_ptr
            localparam logic [WORD_W:0] LO = (WORD_W+1)'(AUTO_BASE);
            localparam logic [WORD_W:0] HI = (WORD_W+1)'(AUTO_BASE + AUTO_CNT);
            p_ptr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (state == S_WRITE_PTR) |->
                    (mem_we && {1'b0, mem_addr} >= LO && {1'b0, mem_addr} < HI));
        end
    endgenerate
endmodule

bind mrx_exec mrx_checker #(
    .WORD_W   (WORD_W),
    .AUTO_BASE(AUTO_BASE),
    .AUTO_CNT (AUTO_CNT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .mem_re  (mem_re),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .pc_out  (pc_out),
    .ac_out  (ac_out),
    .link_out(link_out),
    .ea      (r_q.ea),
    .state   (r_q.state),
    .op      (r_q.op)
);

// File: tb/sim_mrx_exec.sv
`timescale 1ns/1ps
module sim_mrx_exec;
    localparam int N = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0, pc_in = '0, ac_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] mem_addr, mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic        mem_re, mem_we, done, link_out;
    logic [11:0] pc_out, ac_out;

    always #5 clk = ~clk;

    mrx_exec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .pc_in(pc_in), .ac_in(ac_in), .link_in(link_in),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .pc_out(pc_out), .ac_out(ac_out), .link_out(link_out)
    );

    logic [11:0] mem  [N];
    logic [11:0] refm [N];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
        end
    endtask

    // R12: single-port discipline observed at the pins
    always @(negedge clk) begin
        if (rst_n && mem_re && mem_we) begin
            checks++;
            fails++;
            $display("FAIL R12 read/write clash: actual 1 expected 0");
        end
    end

    task automatic run_op(input int op, input bit ind, input bit pg,
                          input logic [6:0] off, input logic [11:0] pc,
                          input logic [11:0] ac, input bit lk, input int seed);
        logic [11:0] ea0, ea, ptr, e_pc, e_ac, v;
        logic [12:0] s;
        bit          e_lk, auto;
        int          lat, cyc;
        bit          mem_ok;
        string       tag, mode;
        for (int i = 0; i < N; i++) begin
            v = 12'((i * 1103 + seed * 77 + 5) & 4095);
            mem[i] = v; refm[i] = v;
        end
        ea0  = pg ? {pc[11:7], off} : {5'b0, off};
        auto = ind && ea0 >= 12'd8 && ea0 <= 12'd15;
        if (auto && seed % 5 == 0) begin mem[ea0] = 12'o7777; refm[ea0] = 12'o7777; end
        ptr = ea0;
        if (!ind)      ea = ea0;
        else if (auto) ea = refm[ea0] + 12'd1;
        else           ea = refm[ea0];
        if (seed % 3 == 0 && !(ind && ea == ea0)) begin
            mem[ea] = 12'o7777; refm[ea] = 12'o7777;
        end
        // arithmetic reference
        e_pc = pc; e_ac = ac; e_lk = lk;
        lat = 2 + (ind ? 1 : 0) + (auto ? 1 : 0);
        if (auto) refm[ptr] = refm[ptr] + 12'd1;
        case (op)
            0: begin e_ac = ac & refm[ea]; lat += 1; end
            1: begin s = {1'b0, ac} + {1'b0, refm[ea]}; e_ac = s[11:0];
                     if (s[12]) e_lk = ~lk; lat += 1; end
            2: begin refm[ea] = refm[ea] + 12'd1; if (refm[ea] == 0) e_pc = pc + 12'd1;
                     lat += 2; end
            3: begin refm[ea] = ac; e_ac = '0; end
            4: begin refm[ea] = pc; e_pc = ea + 12'd1; end
            default: e_pc = ea;
        endcase
        case (op)
            0: tag = "R4"; 1: tag = "R5"; 2: tag = "R6";
            3: tag = "R7"; 4: tag = "R8"; default: tag = "R9";
        endcase
        mode = ind ? (auto ? "R3" : "R2") : "R1";

        @(negedge clk);
        instr = {3'(op), ind, pg, off}; pc_in = pc; ac_in = ac; link_in = lk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 64) begin @(negedge clk); cyc++; end
        chk(done, "R10", "done seen", int'(done), 1);
        chk(cyc == lat, "R10", "latency", cyc, lat);
        chk(pc_out == e_pc, {tag, "/", mode}, "pc_out", pc_out, e_pc);
        chk(ac_out == e_ac, tag, "ac_out", ac_out, e_ac);
        chk(link_out == e_lk, tag, "link_out", int'(link_out), int'(e_lk));
        if (auto) chk(mem[ptr] == refm[ptr], "R3", "pointer writeback", mem[ptr], refm[ptr]);
        mem_ok = 1'b1;
        for (int i = 0; i < N; i++) if (mem[i] !== refm[i]) mem_ok = 1'b0;
        chk(mem_ok, {tag, "/", mode}, "memory image", int'(mem_ok), 1);
        @(negedge clk);
        chk(!done, "R10", "done pulse width", int'(done), 0);
        // R13: idle, inputs wiggle, outputs stay
        ac_in = ~ac; pc_in = ~pc; link_in = ~lk; instr = ~instr;
        repeat (3) @(negedge clk);
        chk(pc_out == e_pc && ac_out == e_ac && link_out == e_lk, "R13", "idle hold",
            {pc_out, ac_out}, {e_pc, e_ac});
    endtask

    initial begin
        logic [6:0]  offs [8];
        logic [11:0] pcs  [3];
        logic [11:0] acs  [6];
        int          idx;
        offs = '{7'd0, 7'd7, 7'd8, 7'd9, 7'd15, 7'd16, 7'd100, 7'd127};
        pcs  = '{12'o0003, 12'o5432, 12'o7777};
        acs  = '{12'o0000, 12'o7777, 12'o4000, 12'o0001, 12'o2322, 12'o5670};
        for (int i = 0; i < N; i++) mem[i] = '0;
        repeat (2) @(negedge clk);
        chk(!done && !mem_re && !mem_we, "R11", "strobes in reset", {done, mem_re, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_re && !mem_we, "R11", "strobes after reset", {done, mem_re, mem_we}, 0);
        chk(pc_out == 0 && ac_out == 0 && link_out == 0, "R11", "outputs after reset",
            {pc_out, ac_out}, 0);
        idx = 0;
        for (int op = 0; op < 6; op++)
            for (int ind = 0; ind < 2; ind++)
                for (int pg = 0; pg < 2; pg++)
                    for (int o = 0; o < 8; o++)
                        for (int p = 0; p < 3; p++) begin
                            run_op(op, ind[0], pg[0], offs[o], pcs[p],
                                   acs[idx % 6], idx[0] ^ idx[3], idx);
                            idx++;
                        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule